// File: doc/BRIEF.md
# Stack and Control-Transfer Sequencer

This block carries out the stack and program-flow part of an 8-bit processor's instructions. It owns the stack pointer and the program counter. Operand decode is left to the caller. The caller supplies five things: an operation code, an optional condition selector, a 16-bit target, the address of the following instruction, and a 16-bit register pair. The block then runs the byte accesses that the operation needs, one at a time, over a memory port with a request/ready handshake.

Pushes store the high byte first, and each store moves the stack pointer down. Pops load the low byte first, and each load moves it up. Calls save the following-instruction address on the stack. Returns restore that address into the program counter. Jumps, calls and returns can each be made conditional on one of eight flag tests. A failed test costs no memory traffic.

Two further operations work on HL. The swap operation exchanges HL with the two bytes at the stack top. The load operation copies HL into the stack pointer. When the last access has been accepted, the block raises a one-cycle completion pulse. It also presents the new program counter, the new stack pointer and, after a pop or a swap, the resulting pair.

Top module: `stack_xfer_seq`

## Requirements
- R1: A push (op 0) writes pair[15:8] to address SP-1 and then pair[7:0] to SP-2. After the push, SP equals the old SP minus 2.
- R2: A pop (op 1) reads the byte at SP as the low half and then the byte at SP+1 as the high half. After the pop, pair_out holds {high, low} and SP equals the old SP plus 2.
- R3: A taken call (op 2) stores next_pc with the same byte order and addresses as R1, leaves SP 2 lower, and sets pc to target.
- R4: A taken return (op 3) reads two bytes with the same order and addresses as R2, sets pc to {high, low}, and leaves SP 2 higher.
- R5: With cond_en low, a jump (op 4), call or return is always taken. With cond_en high it is taken only if the test chosen by cond_sel holds: 0 zero clear, 1 zero set, 2 carry clear, 3 carry set, 4 parity clear, 5 parity set, 6 sign clear, 7 sign set. A taken jump sets pc to target and makes no memory access.
- R6: A swap (op 5) reads the bytes at SP and SP+1, writes pair_in[7:0] to SP and pair_in[15:8] to SP+1, and sets pair_out to {byte at SP+1, byte at SP}. SP does not change.
- R7: Load-SP (op 6) sets SP to pair_in and makes no memory access.
- R8: When a condition fails, pc becomes next_pc, SP is unchanged and mem_req never rises.
- R9: While mem_req is high and mem_ready is low, mem_addr, mem_we and mem_wdata hold steady. done is high for exactly one cycle: the cycle after the last accepted access, or after the accepted start when the operation makes no access.
- R10: SP arithmetic wraps modulo 65536: a push from SP 0x0000 writes to 0xFFFF and then 0xFFFE.
- R11: After reset, pc is 0x0000, SP is 0x0000, pair_out is 0x0000, and done, busy and mem_req are low.
- R12: Push, pop, swap, load-SP and op 7 (no operation) set pc to next_pc. pc and SP change only in the cycle in which done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins an operation; taken only while busy is low |
| op | input | 3 | Operation code (see requirements) |
| cond_en | input | 1 | Makes jump/call/return conditional |
| cond_sel | input | 3 | Flag test selector |
| flag_cy | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| flag_s | input | 1 | Sign flag |
| flag_p | input | 1 | Parity flag |
| target | input | 16 | Jump/call destination |
| next_pc | input | 16 | Address of the following instruction |
| pair_in | input | 16 | Register pair for push, swap and load-SP |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Access address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid with mem_ready |
| mem_ready | input | 1 | Access accepted this cycle |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| pair_out | output | 16 | Pair from the last pop or swap |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Suppose the beat index or a captured read byte is wrong. The error then appears on the memory port within the same operation, as a wrong address, a swapped write order or wrong write data. It appears again on pair_out or pc in the done cycle. A stack pointer that was updated the wrong way shows nothing until the next stack operation, whose addresses are off by the error. For this reason the bench chains each push with a pop or return and compares absolute addresses. A bad condition decode shows in the done cycle, as a pc that holds target where next_pc was expected or the reverse, so all eight tests are driven against all sixteen flag patterns.

// File: rtl/stkseq_pkg.sv
package stkseq_pkg;

  typedef enum logic [2:0] {
    OP_PUSH = 3'd0,
    OP_POP  = 3'd1,
    OP_CALL = 3'd2,
    OP_RET  = 3'd3,
    OP_JMP  = 3'd4,
    OP_SWAP = 3'd5,
    OP_LDSP = 3'd6,
    OP_NOP  = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC  = 2'd1,
    ST_FIN  = 2'd2
  } st_e;

  // sel[2:1] picks the flag, sel[0] says whether it must be set or clear
  function automatic logic cond_hold(input logic [2:0] sel, input logic cy,
                                     input logic z, input logic s, input logic p);
    logic f;
    case (sel[2:1])
      2'd0:    f = z;
      2'd1:    f = cy;
      2'd2:    f = p;
      default: f = s;
    endcase
    return sel[0] ? f : !f;
  endfunction

  // number of byte accesses an operation makes
  function automatic logic [2:0] beat_count(input op_e o, input logic taken);
    case (o)
      OP_PUSH, OP_POP: return 3'd2;
      OP_CALL, OP_RET: return taken ? 3'd2 : 3'd0;
      OP_SWAP:         return 3'd4;
      default:         return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/stkseq_cond.sv
module stkseq_cond (
  input  logic       en,
  input  logic [2:0] sel,
  input  logic       cy,
  input  logic       z,
  input  logic       s,
  input  logic       p,
  output logic       taken
);
  import stkseq_pkg::*;

  always_comb taken = !en || cond_hold(sel, cy, z, s, p);
endmodule

// File: rtl/stkseq_step.sv
module stkseq_step #(
  parameter int DATA_W = 8
) (
  input  stkseq_pkg::op_e      op,
  input  logic                 taken,
  input  logic [1:0]           idx,
  input  logic [2*DATA_W-1:0]  sp,
  input  logic [2*DATA_W-1:0]  wval,
  output logic [2*DATA_W-1:0]  addr,
  output logic                 we,
  output logic [DATA_W-1:0]    wdata,
  output logic                 final_beat
);
  import stkseq_pkg::*;
  localparam int AW = 2 * DATA_W;

  logic [DATA_W-1:0] hi_b, lo_b;
  assign hi_b = wval[AW-1:DATA_W];
  assign lo_b = wval[DATA_W-1:0];

  always_comb begin
    addr  = sp;
    we    = 1'b0;
    wdata = '0;
    case (op)
      OP_PUSH, OP_CALL: begin
        we    = 1'b1;
        addr  = idx[0] ? sp - AW'(2) : sp - AW'(1);
        wdata = idx[0] ? lo_b : hi_b;
      end
      OP_POP, OP_RET: addr = sp + AW'(idx[0]);
      OP_SWAP: begin
        addr  = sp + AW'(idx[0]);
        we    = idx[1];
        wdata = idx[0] ? hi_b : lo_b;
      end
      default: ;
    endcase
  end

  assign final_beat = ({1'b0, idx} + 3'd1) == beat_count(op, taken);
endmodule

// File: rtl/stack_xfer_seq.sv
module stack_xfer_seq #(
  parameter int          DATA_W = 8,
  parameter logic [15:0] SP_RST = 16'h0000,
  parameter logic [15:0] PC_RST = 16'h0000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [2:0]          op,
  input  logic                cond_en,
  input  logic [2:0]          cond_sel,
  input  logic                flag_cy,
  input  logic                flag_z,
  input  logic                flag_s,
  input  logic                flag_p,
  input  logic [2*DATA_W-1:0] target,
  input  logic [2*DATA_W-1:0] next_pc,
  input  logic [2*DATA_W-1:0] pair_in,
  output logic                mem_req,
  output logic                mem_we,
  output logic [2*DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic [DATA_W-1:0]   mem_rdata,
  input  logic                mem_ready,
  output logic [2*DATA_W-1:0] pc,
  output logic [2*DATA_W-1:0] sp,
  output logic [2*DATA_W-1:0] pair_out,
  output logic                busy,
  output logic                done
);
  import stkseq_pkg::*;
  localparam int AW = 2 * DATA_W;

  st_e               st_q;
  op_e               op_q, op_in;
  logic              taken_q, taken_in;
  logic [AW-1:0]     tgt_q, npc_q, pair_q, sp_q, pc_q, pout_q;
  logic [1:0]        idx_q;
  logic [DATA_W-1:0] lo_q, hi_q;

  // named internal events for the checker
  logic ev_accept, ev_beat, ev_last, step_final;

  assign op_in = op_e'(op);

  stkseq_cond u_cond (
    .en(cond_en), .sel(cond_sel), .cy(flag_cy), .z(flag_z),
    .s(flag_s), .p(flag_p), .taken(taken_in)
  );

  stkseq_step #(.DATA_W(DATA_W)) u_step (
    .op(op_q), .taken(taken_q), .idx(idx_q), .sp(sp_q),
    .wval((op_q == OP_CALL) ? npc_q : pair_q),
    .addr(mem_addr), .we(mem_we), .wdata(mem_wdata), .final_beat(step_final)
  );

  assign mem_req   = (st_q == ST_ACC);
  assign ev_accept = (st_q == ST_IDLE) && start;
  assign ev_beat   = mem_req && mem_ready;
  assign ev_last   = ev_beat && step_final;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      op_q    <= OP_NOP;
      taken_q <= 1'b0;
      tgt_q   <= '0;
      npc_q   <= '0;
      pair_q  <= '0;
      idx_q   <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      sp_q    <= SP_RST[AW-1:0];
      pc_q    <= PC_RST[AW-1:0];
      pout_q  <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start) begin
          op_q    <= op_in;
          taken_q <= taken_in;
          tgt_q   <= target;
          npc_q   <= next_pc;
          pair_q  <= pair_in;
          idx_q   <= '0;
          if (beat_count(op_in, taken_in) == 3'd0) begin
            st_q <= ST_FIN;
            pc_q <= (op_in == OP_JMP && taken_in) ? target : next_pc;
            if (op_in == OP_LDSP) sp_q <= pair_in;
          end else begin
            st_q <= ST_ACC;
          end
        end
        ST_ACC: if (mem_ready) begin
          if (!mem_we && !idx_q[0]) lo_q <= mem_rdata;
          if (!mem_we &&  idx_q[0]) hi_q <= mem_rdata;
          idx_q <= idx_q + 2'd1;
          if (step_final) begin
            st_q <= ST_FIN;
            pc_q <= npc_q;
            case (op_q)
              OP_PUSH: sp_q <= sp_q - AW'(2);
              OP_CALL: begin sp_q <= sp_q - AW'(2); pc_q <= tgt_q; end
              OP_POP:  begin sp_q <= sp_q + AW'(2); pout_q <= {mem_rdata, lo_q}; end
              OP_RET:  begin sp_q <= sp_q + AW'(2); pc_q <= {mem_rdata, lo_q}; end
              OP_SWAP: pout_q <= {hi_q, lo_q};
              default: ;
            endcase
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign pc       = pc_q;
  assign sp       = sp_q;
  assign pair_out = pout_q;
  assign busy     = (st_q != ST_IDLE);
  assign done     = (st_q == ST_FIN);
endmodule

// File: rtl/stkseq_chk.sv
module stkseq_chk #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_ready,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic [AW-1:0] pc,
  input logic [AW-1:0] sp,
  input logic          busy,
  input logic          done,
  input logic          ev_accept,
  input logic          ev_last
);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_last_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_last |=> done && !mem_req);

  p_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> busy);

  p_sp_at_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (sp != $past(sp)) |-> done);

  p_pc_at_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (pc != $past(pc)) |-> done);
endmodule

bind stack_xfer_seq stkseq_chk #(.AW(2*DATA_W), .DW(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ready(mem_ready),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .pc(pc), .sp(sp), .busy(busy), .done(done),
  .ev_accept(ev_accept), .ev_last(ev_last)
);

// File: tb/stack_xfer_seq_bench.sv
`timescale 1ns/1ps
module stack_xfer_seq_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk; // 125 MHz

  logic rst_n, start, cond_en, fcy, fz, fs, fp;
  logic [2:0] op, csel;
  logic [15:0] target, next_pc, pair_in;
  logic mem_req, mem_we, mem_ready, busy, done;
  logic [15:0] mem_addr, pc, sp, pair_out;
  logic [7:0] mem_wdata, mem_rdata;

  stack_xfer_seq u_stack_xfer_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .cond_en(cond_en),
    .cond_sel(csel), .flag_cy(fcy), .flag_z(fz), .flag_s(fs), .flag_p(fp),
    .target(target), .next_pc(next_pc), .pair_in(pair_in),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .pc(pc), .sp(sp), .pair_out(pair_out), .busy(busy), .done(done)
  );

  // memory model: 256 bytes by low address byte, programmable wait states
  logic [7:0]  mem [256];
  int          lat = 0, wcnt = 0, nacc = 0, nreq = 0, unstable = 0;
  logic [15:0] alog [8];
  logic        wlog [8];
  logic        prev_wait = 1'b0;
  logic [15:0] prev_addr = '0;

  assign mem_ready = mem_req && (wcnt >= lat);
  assign mem_rdata = mem[mem_addr[7:0]];

  always @(posedge clk) begin
    if (mem_req && !mem_ready) wcnt <= wcnt + 1; else wcnt <= 0;
    if (mem_req) nreq <= nreq + 1;
    if (mem_req && mem_ready) begin
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      if (nacc < 8) begin alog[nacc] <= mem_addr; wlog[nacc] <= mem_we; end
      nacc <= nacc + 1;
    end
    if (prev_wait && mem_addr != prev_addr) unstable <= unstable + 1;
    prev_wait <= mem_req && !mem_ready;
    prev_addr <= mem_addr;
  end

  int errors = 0, checks = 0, cycles = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // runs one operation, returns after done has been seen, and checks the pulse width
  task automatic run_op(input logic [2:0] o, input logic ce, input logic [2:0] cs,
                        input logic [15:0] tg, input logic [15:0] np, input logic [15:0] pr);
    @(negedge clk);
    op = o; cond_en = ce; csel = cs; target = tg; next_pc = np; pair_in = pr;
    nacc = 0; nreq = 0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cycles = 0;
    while (!done && cycles < 1000) begin @(negedge clk); cycles++; end
    check("R9 done seen", done, 1'b1);
    @(negedge clk);
    check("R9 one-cycle done", done, 1'b0);
  endtask

  function automatic logic cond_ref(input logic [2:0] s, input logic cy, z, sg, p);
    case (s)
      3'd0: return z == 1'b0;
      3'd1: return z == 1'b1;
      3'd2: return cy == 1'b0;
      3'd3: return cy == 1'b1;
      3'd4: return p == 1'b0;
      3'd5: return p == 1'b1;
      3'd6: return sg == 1'b0;
      default: return sg == 1'b1;
    endcase
  endfunction

  task automatic t_reset;
    check("R11 pc", pc, 16'h0000);
    check("R11 sp", sp, 16'h0000);
    check("R11 pair_out", pair_out, 16'h0000);
    check("R11 done/busy/req", {done, busy, mem_req}, 3'b000);
  endtask

  task automatic t_ldsp;
    run_op(3'd6, 0, 0, 16'h9999, 16'h0101, 16'h1080);
    check("R7 sp", sp, 16'h1080);
    check("R7 no access", nreq, 0);
    check("R12 pc after ldsp", pc, 16'h0101);
    check("R9 no-access timing", cycles, 0);
  endtask

  task automatic t_push_pop;
    run_op(3'd0, 0, 0, 16'h0, 16'h0110, 16'hABCD);
    check("R1 sp", sp, 16'h107E);
    check("R1 first addr", alog[0], 16'h107F);
    check("R1 second addr", alog[1], 16'h107E);
    check("R1 writes", {wlog[0], wlog[1]}, 2'b11);
    check("R1 high byte", mem[8'h7F], 8'hAB);
    check("R1 low byte", mem[8'h7E], 8'hCD);
    check("R12 pc after push", pc, 16'h0110);
    check("R9 zero-wait timing", cycles, 2);
    run_op(3'd1, 0, 0, 16'h0, 16'h0120, 16'h0000);
    check("R2 pair_out", pair_out, 16'hABCD);
    check("R2 sp", sp, 16'h1080);
    check("R2 order", {alog[0], alog[1]}, {16'h107E, 16'h107F});
    check("R2 reads", {wlog[0], wlog[1]}, 2'b00);
    check("R12 pc after pop", pc, 16'h0120);
  endtask

  task automatic t_call_ret;
    run_op(3'd2, 0, 0, 16'h4000, 16'h0203, 16'h1111);
    check("R3 pc", pc, 16'h4000);
    check("R3 sp", sp, 16'h107E);
    check("R3 saved", {mem[8'h7F], mem[8'h7E]}, 16'h0203);
    check("R3 order", alog[0], 16'h107F);
    run_op(3'd3, 0, 0, 16'h5555, 16'h4001, 16'h0000);
    check("R4 pc", pc, 16'h0203);
    check("R4 sp", sp, 16'h1080);
  endtask

  task automatic t_conds;
    for (int s = 0; s < 8; s++) begin
      for (int f = 0; f < 16; f++) begin
        logic exp_t;
        fcy = f[0]; fz = f[1]; fs = f[2]; fp = f[3];
        exp_t = cond_ref(3'(s), fcy, fz, fs, fp);
        run_op(3'd4, 1'b1, 3'(s), 16'hC000, 16'h0300, 16'h0);
        check("R5 conditional jump", pc, exp_t ? 16'hC000 : 16'h0300);
        if (!exp_t) check("R8 jump no access", nreq, 0);
      end
    end
    fz = 1'b1;
    run_op(3'd4, 1'b0, 3'd1 ^ 3'd1, 16'hC100, 16'h0310, 16'h0);
    check("R5 unconditional jump", pc, 16'hC100);
  endtask

  task automatic t_false_call_ret;
    fcy = 1'b0;
    run_op(3'd2, 1'b1, 3'd3, 16'h7000, 16'h0400, 16'h0);
    check("R8 call pc", pc, 16'h0400);
    check("R8 call sp", sp, 16'h1080);
    check("R8 call no access", nreq, 0);
    run_op(3'd3, 1'b1, 3'd3, 16'h7000, 16'h0410, 16'h0);
    check("R8 ret pc", pc, 16'h0410);
    check("R8 ret sp", sp, 16'h1080);
    check("R8 ret no access", nreq, 0);
    fcy = 1'b1;
    run_op(3'd2, 1'b1, 3'd3, 16'h7100, 16'h0420, 16'h0);
    check("R3 conditional call taken", {pc, sp}, {16'h7100, 16'h107E});
    run_op(3'd3, 1'b1, 3'd3, 16'h0, 16'h7101, 16'h0);
    check("R4 conditional return taken", {pc, sp}, {16'h0420, 16'h1080});
  endtask

  task automatic t_swap;
    mem[8'h80] = 8'h11; mem[8'h81] = 8'h22;
    run_op(3'd5, 0, 0, 16'h0, 16'h0500, 16'h3344);
    check("R6 pair_out", pair_out, 16'h2211);
    check("R6 mem sp", mem[8'h80], 8'h44);
    check("R6 mem sp+1", mem[8'h81], 8'h33);
    check("R6 sp unchanged", sp, 16'h1080);
    check("R6 access count", nacc, 4);
    check("R12 pc after swap", pc, 16'h0500);
  endtask

  task automatic t_wrap;
    run_op(3'd6, 0, 0, 16'h0, 16'h0600, 16'h0000);
    run_op(3'd0, 0, 0, 16'h0, 16'h0601, 16'h5A6B);
    check("R10 first addr", alog[0], 16'hFFFF);
    check("R10 second addr", alog[1], 16'hFFFE);
    check("R10 sp", sp, 16'hFFFE);
    run_op(3'd1, 0, 0, 16'h0, 16'h0602, 16'h0);
    check("R10 pop wrap sp", sp, 16'h0000);
    check("R10 pop value", pair_out, 16'h5A6B);
  endtask

  task automatic t_wait;
    run_op(3'd6, 0, 0, 16'h0, 16'h0700, 16'h1080);
    lat = 3; unstable = 0;
    run_op(3'd0, 0, 0, 16'h0, 16'h0701, 16'hBEEF);
    check("R9 wait timing", cycles, 8);
    check("R9 stable during wait", unstable, 0);
    check("R9 data with waits", {mem[8'h7F], mem[8'h7E]}, 16'hBEEF);
    run_op(3'd7, 0, 0, 16'h0, 16'h0702, 16'h0);
    check("R12 nop pc", pc, 16'h0702);
    check("R12 nop sp", sp, 16'h107E);
    lat = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    rst_n = 1'b0; start = 1'b0; op = 3'd7; cond_en = 1'b0; csel = 3'd0;
    fcy = 1'b0; fz = 1'b0; fs = 1'b0; fp = 1'b0;
    target = '0; next_pc = '0; pair_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ldsp();
    t_push_pop();
    t_call_ret();
    t_conds();
    t_false_call_ret();
    t_swap();
    t_wrap();
    t_wait();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule